// File: doc/BRIEF.md
# GF(2^64) Multiplicative Inverse Sequencer

This block returns the multiplicative inverse of a 64-bit element of the binary field GF(2^64). The field is defined by the polynomial x^64 + x^4 + x^3 + x + 1, so any x^64 term folds back as the constant 0x1b. The block raises the operand to the power 2^64 - 2 using a fixed sequence of squarings and products. All of these steps run on a single shared field multiplier. That multiplier is a carry-less 64x64 product followed by a two-stage fold back to 64 bits.

A client pulses `start_i` for one cycle with the element on `operand_i`. `busy_o` is high while the sequence runs. `done_o` is then high for exactly one cycle, and the inverse is on `result_o`. The result holds until the next accepted start. First the operand is squared into both working registers (`x` and `y`). Then 62 rounds follow. Each round squares `x` and multiplies the new `x` into `y`. The final `y` is the answer.

Top module: `gf64_inv`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy_o` and `done_o` are 0 and `result_o` is all zeros.
- R2: For any non-zero operand, the field product of the operand and `result_o` equals 1. The product is reduced with x^64 = 0x1b, where bit i of a word is the coefficient of x^i.
- R3: An operand of zero yields a result of zero.
- R4: An operand of one yields a result of one.
- R5: `done_o` is high for exactly one cycle. It rises 125 cycles (2*(W-2)+1) after the clock edge at which the start was accepted.
- R6: `busy_o` is high from the cycle after an accepted start until `done_o` rises. `busy_o` and `done_o` are never high together.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running inversion completes with its original operand, and its timing does not change.
- R8: While `busy_o` is low, `result_o` does not change. After `done_o`, the inverse stays on `result_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when the block is idle |
| operand_i | input | 64 | Field element to invert, sampled with an accepted start |
| busy_o | output | 1 | Inversion sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Inverse of the last accepted operand |

## Verification
The assertions assume a start is raised only while the block is idle, or else ignored. They also assume the operand is stable at the accepting edge. The bench drives the operand and start together at the falling edge and drops start after one edge. Only the deliberate collision test raises start mid-run, and it does so while `busy_o` is high, never in the done cycle. The bench's own field multiplier is a shift-and-reduce loop, so the inverse property is judged without borrowing the design's carry-less fold.

// File: rtl/gf64_inv_pkg.sv
package gf64_inv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT_SQ,
        ST_SQ,
        ST_MUL,
        ST_DONE
    } inv_state_e;

    // Datapath steering issued by the sequencer each cycle
    typedef struct packed {
        logic ld_op;   // capture the incoming operand into x
        logic ld_x;    // x <= multiplier output
        logic ld_y;    // y <= multiplier output
        logic sel_sq;  // 1: multiply x by x, 0: multiply x by y
    } dp_ctrl_t;

    localparam dp_ctrl_t CTRL_NONE = '{ld_op: 1'b0, ld_x: 1'b0, ld_y: 1'b0, sel_sq: 1'b0};

endpackage

// File: rtl/gf64_clmul.sv
module gf64_clmul #(
    parameter int AW = 64,
    parameter int BW = 8,
    localparam int PW = AW + BW - 1
) (
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    output logic [PW-1:0] p_o
);
    logic [PW-1:0] a_ext;
    assign a_ext = {{(PW-AW){1'b0}}, a_i};

    always_comb begin
        p_o = '0;
        for (int i = 0; i < BW; i++) begin
            if (b_i[i]) p_o = p_o ^ (a_ext << i);
        end
    end
endmodule

// File: rtl/gf64_fold.sv
module gf64_fold #(
    parameter int W = 64,
    parameter int PD = 8,
    parameter logic [PD-1:0] POLY = 8'h1b
) (
    input  logic [2*W-2:0] prod_i,
    output logic [W-1:0]   res_o
);
    localparam int T1W = (W - 1) + PD - 1;
    localparam int OVW = T1W - W;
    localparam int T2W = OVW + PD - 1;

    logic [W-2:0]   hi;
    logic [T1W-1:0] t1;
    logic [T2W-1:0] t2;

    assign hi = prod_i[2*W-2:W];

    // first fold: x^64 and above times the low-order polynomial terms
    gf64_clmul #(.AW(W-1), .BW(PD)) u_fold1 (
        .a_i(hi), .b_i(POLY), .p_o(t1)
    );

    // second fold: the few bits that spilled past x^63 again
    gf64_clmul #(.AW(OVW), .BW(PD)) u_fold2 (
        .a_i(t1[T1W-1:W]), .b_i(POLY), .p_o(t2)
    );

    assign res_o = prod_i[W-1:0] ^ t1[W-1:0] ^ {{(W-T2W){1'b0}}, t2};
endmodule

// File: rtl/gf64_field_mul.sv
module gf64_field_mul #(
    parameter int W = 64,
    parameter int PD = 8,
    parameter logic [PD-1:0] POLY = 8'h1b
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o
);
    logic [2*W-2:0] full;

    gf64_clmul #(.AW(W), .BW(W)) u_clmul (
        .a_i(a_i), .b_i(b_i), .p_o(full)
    );

    gf64_fold #(.W(W), .PD(PD), .POLY(POLY)) u_fold (
        .prod_i(full), .res_o(p_o)
    );
endmodule

// File: rtl/gf64_inv_fsm.sv
module gf64_inv_fsm
    import gf64_inv_pkg::*;
#(
    parameter int ROUNDS = 62,
    localparam int CW = $clog2(ROUNDS)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output dp_ctrl_t ctrl_o,
    output logic     busy_o,
    output logic     done_o
);
    inv_state_e    state, state_nx;
    logic [CW-1:0] rnd, rnd_nx;

    always_comb begin
        state_nx = state;
        rnd_nx   = rnd;
        ctrl_o   = CTRL_NONE;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_o.ld_op = 1'b1;
                    state_nx     = ST_INIT_SQ;
                end
            end
            ST_INIT_SQ: begin
                ctrl_o.sel_sq = 1'b1;
                ctrl_o.ld_x   = 1'b1;
                ctrl_o.ld_y   = 1'b1;
                rnd_nx        = '0;
                state_nx      = ST_SQ;
            end
            ST_SQ: begin
                ctrl_o.sel_sq = 1'b1;
                ctrl_o.ld_x   = 1'b1;
                state_nx      = ST_MUL;
            end
            ST_MUL: begin
                ctrl_o.ld_y = 1'b1;
                if (rnd == CW'(ROUNDS - 1)) begin
                    state_nx = ST_DONE;
                end else begin
                    rnd_nx   = rnd + 1'b1;
                    state_nx = ST_SQ;
                end
            end
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rnd   <= '0;
        end else begin
            state <= state_nx;
            rnd   <= rnd_nx;
        end
    end

    assign busy_o = (state != ST_IDLE) && (state != ST_DONE);
    assign done_o = (state == ST_DONE);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R6
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !done_o) |=> busy_o);

    // R5
    round_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rnd <= CW'(ROUNDS - 1));
endmodule

// File: rtl/gf64_inv.sv
module gf64_inv
    import gf64_inv_pkg::*;
#(
    parameter int W = 64,
    parameter int PD = 8,
    parameter logic [PD-1:0] POLY = 8'h1b,
    localparam int ROUNDS = W - 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] operand_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    dp_ctrl_t     ctrl;
    logic [W-1:0] x_q, y_q;
    logic [W-1:0] mul_b, mul_p;

    gf64_inv_fsm #(.ROUNDS(ROUNDS)) u_fsm (
        .clk(clk), .rst(rst), .start_i(start_i),
        .ctrl_o(ctrl), .busy_o(busy_o), .done_o(done_o)
    );

    assign mul_b = ctrl.sel_sq ? x_q : y_q;

    gf64_field_mul #(.W(W), .PD(PD), .POLY(POLY)) u_mul (
        .a_i(x_q), .b_i(mul_b), .p_o(mul_p)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (ctrl.ld_op) begin
            x_q <= operand_i;
        end else begin
            if (ctrl.ld_x) x_q <= mul_p;
            if (ctrl.ld_y) y_q <= mul_p;
        end
    end

    assign result_o = y_q;

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(result_o));

    // R3
    zero_prop_chk: assert property (@(posedge clk) disable iff (rst)
        (x_q == '0) |-> (mul_p == '0));
endmodule

// File: tb/gf64_inv_tb.sv
module gf64_inv_tb;
    localparam int W = 64;
    localparam int LAT = 2 * (W - 2) + 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic [W-1:0] operand_i;
    logic         busy_o, done_o;
    logic [W-1:0] result_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    gf64_inv u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .operand_i(operand_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r = '0;
        logic [W-1:0] s = a;
        for (int i = 0; i < W; i++) begin
            if (b[i]) r ^= s;
            s = s[W-1] ? ((s << 1) ^ 64'h1b) : (s << 1);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // runs one inversion; poke_at > 0 raises start again at that cycle count
    task automatic run_inv(input logic [W-1:0] op, input int poke_at,
                           output logic [W-1:0] res, output int lat);
        logic busy_ok = 1'b1;
        @(negedge clk);
        start_i   = 1'b1;
        operand_i = op;
        @(posedge clk);
        @(negedge clk);
        start_i   = 1'b0;
        operand_i = ~op;
        lat = 0;
        for (int k = 0; k < 400; k++) begin
            if (poke_at > 0 && lat == poke_at) start_i = 1'b1;
            @(posedge clk);
            lat++;
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) break;
            if (!busy_o) busy_ok = 1'b0;
        end
        res = result_o;
        // R6 busy throughout run, exclusive with done
        chk("R6 busy during run", {63'd0, busy_ok}, 64'd1);
        chk("R6 busy low at done", {63'd0, busy_o}, 64'd0);
        // R5 latency
        chk("R5 latency", 64'(lat), 64'(LAT));
        @(negedge clk);
        chk("R5 done single cycle", {63'd0, done_o}, 64'd0);
    endtask

    initial begin
        logic [W-1:0] res, op, res2;
        int lat;
        rst = 1'b1;
        start_i = 1'b0;
        operand_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk("R1 busy", {63'd0, busy_o}, 64'd0);
        chk("R1 done", {63'd0, done_o}, 64'd0);
        chk("R1 result", result_o, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after release", {63'd0, busy_o}, 64'd0);
        chk("R1 result after release", result_o, 64'd0);

        // R4 identity
        run_inv(64'd1, 0, res, lat);
        chk("R4 inverse of one", res, 64'd1);

        // R3 zero maps to zero
        run_inv(64'd0, 0, res, lat);
        chk("R3 inverse of zero", res, 64'd0);

        // R2 structured operands: single bits and the top bit
        for (int b = 1; b < W; b += 9) begin
            op = 64'd1 << b;
            run_inv(op, 0, res, lat);
            chk("R2 single bit", ref_mul(op, res), 64'd1);
        end
        op = '1;
        run_inv(op, 0, res, lat);
        chk("R2 all ones", ref_mul(op, res), 64'd1);

        // R2 random non-zero operands, plus double inversion
        for (int n = 0; n < 20; n++) begin
            op = {$urandom(), $urandom()};
            if (op == '0) op = 64'h5;
            run_inv(op, 0, res, lat);
            chk("R2 random", ref_mul(op, res), 64'd1);
            if (n < 3) begin
                run_inv(res, 0, res2, lat);
                chk("R2 double inverse", res2, op);
            end
        end

        // R8 result holds while idle
        op = 64'h0123_4567_89ab_cdef;
        run_inv(op, 0, res, lat);
        repeat (6) @(negedge clk);
        chk("R8 result held", result_o, res);
        chk("R8 result correct", ref_mul(op, res), 64'd1);

        // R7 start while busy ignored
        op = 64'hdead_beef_0bad_f00d;
        run_inv(op, 10, res, lat);
        chk("R7 collision result", ref_mul(op, res), 64'd1);
        repeat (4) @(negedge clk);
        chk("R7 no second run", {63'd0, busy_o}, 64'd0);
        chk("R7 result unchanged", result_o, res);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule